// File: doc/BRIEF.md
# Synchronous Character Hunt Receiver

This block is the receive side of a synchronous serial link. It takes one serial data bit on every rising edge of the receive bit clock. That edge reaches the block as a one-cycle strobe in the system clock domain. The block first finds character alignment by hunting for one or two programmable sync characters. After lock it assembles characters of 5 to 8 data bits, least significant bit first, each optionally followed by a parity bit. Completed characters go into a single holding register that has a ready flag. The block reports parity and overrun errors. It raises a sync-detect flag on lock and again whenever the sync pattern reappears on a character boundary.

In internal mode, alignment is found by comparing the incoming bit stream with the sync characters. In external mode, alignment is forced by a high level on the sync input, and the internal comparison is switched off. An enter-hunt command restarts the search. The receiver's configuration (character length, parity, sync mode, sync characters, enable) arrives on plain input ports. An asynchronous-mode input parks the receiver completely.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, hunting is 1 and syncDetect, rxReady, parityErr, overrunErr and rxDataOut are all 0. The shift register is all ones.
- R2: Internal mode, one sync character. While hunting, the low L bits of the shift register are compared with the low L bits of syncChar1 after every received bit. L is 5 + charLen, with charLen 0..3 giving 5..8 bits. Bits enter least significant bit first, so the earliest bit of the window is bit 0. When parity is off, a match clears hunting and sets syncDetect on the clock edge that takes the matching bit.
- R3: Double-sync mode (singleSync = 0). After syncChar1 is found, the next full frame must carry syncChar2 before hunting ends. If that frame does not match, the bit-by-bit search for syncChar1 resumes.
- R4: With parity enabled (parityEn = 1), the lock and the syncDetect set are taken on the parity bit that follows the matching character, not on its last data bit.
- R5: A statusRead pulse clears syncDetect without changing hunting. A set in the same cycle wins over the clear.
- R6: An enterHunt pulse sets hunting, restarts the frame, and loads ones into the low L bits of the shift register. An all-ones sync character therefore matches on the first received 1.
- R7: While asyncMode is 1, enterHunt, received bits and syncIn have no effect on alignment or on the holding register.
- R8: Once locked, each frame of L data bits (plus a parity bit when parityEn = 1) is assembled with the first bit in bit 0 and zero-extended. At the frame's last bit it is copied into rxDataOut and rxReady is set. A dataRead pulse clears rxReady.
- R9: After lock in internal mode, sync matching happens only at frame ends. In single mode a character equal to syncChar1 sets syncDetect. In double mode syncChar1 followed directly by syncChar2 sets it, and syncChar1 alone does not.
- R10: When locked and parityEn = 1, the parity bit is checked whether or not rxEnable is 1. parityEven = 1 demands an even count of ones over data and parity, and 0 demands an odd count. A failed check sets parityErr. errorReset clears parityErr.
- R11: A character that completes while rxReady is still 1 replaces the held character and sets overrunErr, even if a dataRead arrives in the same cycle. errorReset clears overrunErr.
- R12: While rxEnable is 0, rxReady is held at 0 and completed characters are not copied to rxDataOut.
- R13: In external mode (extSyncMode = 1), the bit stream never ends a hunt. A high syncIn while hunting clears hunting and sets syncDetect on the next clock edge. The next bit strobe after that is bit 0 of a character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitStrobe | input | 1 | One-cycle pulse marking a rising edge of the receive bit clock |
| rxData | input | 1 | Serial data, sampled when bitStrobe is 1 |
| syncIn | input | 1 | External sync level, used when extSyncMode is 1 |
| asyncMode | input | 1 | Parks the receiver; enterHunt is ignored |
| extSyncMode | input | 1 | 1 = alignment comes from syncIn, 0 = internal pattern match |
| singleSync | input | 1 | 1 = one sync character, 0 = two in sequence |
| charLen | input | LEN_W | Data bits per character minus MIN_LEN |
| parityEn | input | 1 | A parity bit follows the data bits |
| parityEven | input | 1 | 1 = even parity, 0 = odd parity |
| syncChar1 | input | DATA_W | First sync character (low L bits used) |
| syncChar2 | input | DATA_W | Second sync character (low L bits used) |
| rxEnable | input | 1 | Allows transfer to the holding register |
| enterHunt | input | 1 | Command pulse: restart the hunt |
| errorReset | input | 1 | Command pulse: clear parityErr and overrunErr |
| statusRead | input | 1 | Pulse: status was read, clears syncDetect |
| dataRead | input | 1 | Pulse: holding register was read, clears rxReady |
| rxDataOut | output | DATA_W | Holding register, zero-extended character |
| rxReady | output | 1 | A character is waiting in rxDataOut |
| syncDetect | output | 1 | Sticky sync-detect flag |
| hunting | output | 1 | 1 while character alignment has not been found |
| parityErr | output | 1 | Sticky parity error |
| overrunErr | output | 1 | Sticky overrun error |

## Verification
The assertions assume that bitStrobe is a single-cycle pulse and that syncIn is raised only in external mode. They also assume that the configuration inputs (charLen, parityEn, singleSync, extSyncMode) change only at frame boundaries or just before an enterHunt. The stimulus spaces bit strobes four clock cycles apart. It never places a status or data read on a strobe cycle. It changes the configuration only between complete frames or together with a new hunt. With those constraints kept, the receiver's alignment and the expected frame positions stay well defined in both the design and the reference.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

  typedef enum logic [1:0] {
    ST_HUNT1 = 2'd0,
    ST_PAR1  = 2'd1,
    ST_HUNT2 = 2'd2,
    ST_LOCK  = 2'd3
  } huntState_e;

  typedef struct packed {
    logic shiftEn;
    logic presetOnes;
    logic loadHold;
  } dpStrobe_t;

endpackage

// File: rtl/sync_hunt_dp.sv
module sync_hunt_dp
  import sync_hunt_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxData,
  input  logic [LEN_W-1:0]  charLen,
  input  logic              parityEven,
  input  logic [DATA_W-1:0] syncChar1,
  input  logic [DATA_W-1:0] syncChar2,
  input  dpStrobe_t         ctl,
  output logic              matchSync1,
  output logic              matchSync2,
  output logic              parityOk,
  output logic [DATA_W-1:0] holdData
);

  localparam int CNT_W = $clog2(DATA_W + 2);

  logic [CNT_W-1:0]  lenVal;
  logic [DATA_W-1:0] charMask;
  logic [DATA_W-1:0] shiftQ;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] shiftNext;
  logic [DATA_W-1:0] candidate;
  logic [DATA_W-1:0] holdQ;

  assign lenVal  = CNT_W'(MIN_LEN) + CNT_W'(charLen);
  assign shifted = shiftQ >> 1;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      charMask[i]  = (i < int'(lenVal));
      shiftNext[i] = (i == int'(lenVal) - 1) ? rxData : (shifted[i] & charMask[i]);
    end
  end

  assign candidate  = (ctl.shiftEn ? shiftNext : shiftQ) & charMask;
  assign matchSync1 = (candidate == (syncChar1 & charMask));
  assign matchSync2 = (candidate == (syncChar2 & charMask));
  assign parityOk   = ((^candidate) ^ rxData) == !parityEven;
  assign holdData   = holdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '1;
      holdQ  <= '0;
    end else begin
      if (ctl.presetOnes) begin
        shiftQ <= charMask;
      end else if (ctl.shiftEn) begin
        shiftQ <= shiftNext;
      end
      if (ctl.loadHold) begin
        holdQ <= candidate;
      end
    end
  end

endmodule

// File: rtl/sync_hunt_ctrl.sv
module sync_hunt_ctrl
  import sync_hunt_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitStrobe,
  input  logic             syncIn,
  input  logic             asyncMode,
  input  logic             extSyncMode,
  input  logic             singleSync,
  input  logic [LEN_W-1:0] charLen,
  input  logic             parityEn,
  input  logic             rxEnable,
  input  logic             enterHunt,
  input  logic             errorReset,
  input  logic             statusRead,
  input  logic             dataRead,
  input  logic             matchSync1,
  input  logic             matchSync2,
  input  logic             parityOk,
  output dpStrobe_t        ctl,
  output logic             hunting,
  output logic             syncDetect,
  output logic             rxReady,
  output logic             parityErr,
  output logic             overrunErr
);

  localparam int CNT_W = $clog2(DATA_W + 2);

  huntState_e       state, stateN;
  logic [CNT_W-1:0] idx, idxN;
  logic [CNT_W-1:0] lenVal;
  logic [CNT_W-1:0] lastIdx;
  logic             prevSync1, prevN;
  logic             setSync;
  logic             sync1Done;
  logic             parFail;
  logic             lastBit;

  assign lenVal  = CNT_W'(MIN_LEN) + CNT_W'(charLen);
  assign lastIdx = lenVal + CNT_W'(parityEn) - CNT_W'(1);
  assign lastBit = (idx == lastIdx);

  always_comb begin
    stateN    = state;
    idxN      = idx;
    prevN     = prevSync1;
    setSync   = 1'b0;
    sync1Done = 1'b0;
    parFail   = 1'b0;
    ctl       = '0;
    if (enterHunt && !asyncMode) begin
      stateN         = ST_HUNT1;
      idxN           = '0;
      prevN          = 1'b0;
      ctl.presetOnes = 1'b1;
    end else if (!asyncMode) begin
      if (extSyncMode && syncIn && state != ST_LOCK) begin
        setSync = 1'b1;
        stateN  = ST_LOCK;
        idxN    = '0;
        prevN   = 1'b0;
      end else begin
        if (extSyncMode && syncIn) begin
          setSync = 1'b1;
        end
        if (bitStrobe) begin
          case (state)
            ST_HUNT1: begin
              if (!extSyncMode) begin
                ctl.shiftEn = 1'b1;
                if (matchSync1) begin
                  if (parityEn) stateN = ST_PAR1;
                  else          sync1Done = 1'b1;
                end
              end
            end
            ST_PAR1: begin
              sync1Done = 1'b1;
            end
            ST_HUNT2: begin
              ctl.shiftEn = (idx < lenVal);
              if (lastBit) begin
                idxN = '0;
                if (matchSync2) begin
                  stateN  = ST_LOCK;
                  setSync = 1'b1;
                  prevN   = 1'b0;
                end else begin
                  stateN = ST_HUNT1;
                end
              end else begin
                idxN = idx + CNT_W'(1);
              end
            end
            default: begin
              ctl.shiftEn = (idx < lenVal);
              if (lastBit) begin
                idxN         = '0;
                ctl.loadHold = rxEnable;
                parFail      = parityEn && !parityOk;
                if (!extSyncMode) begin
                  if (singleSync) setSync = setSync | matchSync1;
                  else            setSync = setSync | (prevSync1 && matchSync2);
                  prevN = matchSync1;
                end
              end else begin
                idxN = idx + CNT_W'(1);
              end
            end
          endcase
          if (sync1Done) begin
            idxN = '0;
            if (singleSync) begin
              stateN  = ST_LOCK;
              setSync = 1'b1;
              prevN   = 1'b0;
            end else begin
              stateN = ST_HUNT2;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_HUNT1;
      idx        <= '0;
      prevSync1  <= 1'b0;
      syncDetect <= 1'b0;
      rxReady    <= 1'b0;
      parityErr  <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      state     <= stateN;
      idx       <= idxN;
      prevSync1 <= prevN;
      if (setSync)         syncDetect <= 1'b1;
      else if (statusRead) syncDetect <= 1'b0;
      if (!rxEnable)         rxReady <= 1'b0;
      else if (ctl.loadHold) rxReady <= 1'b1;
      else if (dataRead)     rxReady <= 1'b0;
      if (ctl.loadHold && rxReady) overrunErr <= 1'b1;
      else if (errorReset)         overrunErr <= 1'b0;
      if (parFail)         parityErr <= 1'b1;
      else if (errorReset) parityErr <= 1'b0;
    end
  end

  assign hunting = (state != ST_LOCK);

endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
  import sync_hunt_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStrobe,
  input  logic              rxData,
  input  logic              syncIn,
  input  logic              asyncMode,
  input  logic              extSyncMode,
  input  logic              singleSync,
  input  logic [LEN_W-1:0]  charLen,
  input  logic              parityEn,
  input  logic              parityEven,
  input  logic [DATA_W-1:0] syncChar1,
  input  logic [DATA_W-1:0] syncChar2,
  input  logic              rxEnable,
  input  logic              enterHunt,
  input  logic              errorReset,
  input  logic              statusRead,
  input  logic              dataRead,
  output logic [DATA_W-1:0] rxDataOut,
  output logic              rxReady,
  output logic              syncDetect,
  output logic              hunting,
  output logic              parityErr,
  output logic              overrunErr
);

  dpStrobe_t ctl;
  logic      matchSync1;
  logic      matchSync2;
  logic      parityOk;

  sync_hunt_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .syncIn(syncIn),
    .asyncMode(asyncMode), .extSyncMode(extSyncMode), .singleSync(singleSync),
    .charLen(charLen), .parityEn(parityEn), .rxEnable(rxEnable),
    .enterHunt(enterHunt), .errorReset(errorReset), .statusRead(statusRead),
    .dataRead(dataRead), .matchSync1(matchSync1), .matchSync2(matchSync2),
    .parityOk(parityOk), .ctl(ctl), .hunting(hunting), .syncDetect(syncDetect),
    .rxReady(rxReady), .parityErr(parityErr), .overrunErr(overrunErr)
  );

  sync_hunt_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .rxData(rxData), .charLen(charLen),
    .parityEven(parityEven), .syncChar1(syncChar1), .syncChar2(syncChar2),
    .ctl(ctl), .matchSync1(matchSync1), .matchSync2(matchSync2),
    .parityOk(parityOk), .holdData(rxDataOut)
  );

endmodule

// File: rtl/sync_hunt_chk.sv
module sync_hunt_chk (
  input logic clk,
  input logic rstN,
  input logic bitStrobe,
  input logic syncIn,
  input logic asyncMode,
  input logic extSyncMode,
  input logic parityEn,
  input logic rxEnable,
  input logic enterHunt,
  input logic statusRead,
  input logic rxReady,
  input logic syncDetect,
  input logic hunting,
  input logic parityErr,
  input logic overrunErr
);

  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hunting) |-> ($past(bitStrobe) || $past(syncIn))); // R2

  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !bitStrobe && !(syncIn && extSyncMode)) |=> !syncDetect); // R5

  AST_HUNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (enterHunt && !asyncMode) |=> hunting); // R6

  AST_ASYNC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    asyncMode |=> $stable(hunting)); // R7

  AST_READY_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> ($past(bitStrobe) && !$past(hunting))); // R8

  AST_PARITY_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> ($past(parityEn) && $past(bitStrobe) && !$past(hunting))); // R10

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(rxReady)); // R11

  AST_READY_LOW_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !rxReady); // R12

endmodule

bind sync_hunt_rx sync_hunt_chk i_chk (.*);

// File: tb/test_sync_hunt_rx.sv
module test_sync_hunt_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitStrobe = 1'b0;
  logic       rxData = 1'b1;
  logic       syncIn = 1'b0;
  logic       asyncMode = 1'b0;
  logic       extSyncMode = 1'b0;
  logic       singleSync = 1'b1;
  logic [1:0] charLen = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityEven = 1'b0;
  logic [7:0] syncChar1 = 8'h16;
  logic [7:0] syncChar2 = 8'h68;
  logic       rxEnable = 1'b1;
  logic       enterHunt = 1'b0;
  logic       errorReset = 1'b0;
  logic       statusRead = 1'b0;
  logic       dataRead = 1'b0;
  logic [7:0] rxDataOut;
  logic       rxReady, syncDetect, hunting, parityErr, overrunErr;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sync_hunt_rx i_sync_hunt_rx (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .rxData(rxData),
    .syncIn(syncIn), .asyncMode(asyncMode), .extSyncMode(extSyncMode),
    .singleSync(singleSync), .charLen(charLen), .parityEn(parityEn),
    .parityEven(parityEven), .syncChar1(syncChar1), .syncChar2(syncChar2),
    .rxEnable(rxEnable), .enterHunt(enterHunt), .errorReset(errorReset),
    .statusRead(statusRead), .dataRead(dataRead), .rxDataOut(rxDataOut),
    .rxReady(rxReady), .syncDetect(syncDetect), .hunting(hunting),
    .parityErr(parityErr), .overrunErr(overrunErr)
  );

  // behavioural reference model
  int mSt = 0;        // 0 hunt1, 1 parity after sync1, 2 hunt2, 3 locked
  bit mQ[$];
  int mIdx = 0;
  int mChar = 0;
  bit mPrev = 0;
  int mHold = 0;
  bit mReady = 0, mOvr = 0, mPerr = 0, mSync = 0;

  function automatic int windowVal(int len);
    int v = 0;
    for (int i = 0; i < len; i++) begin
      if (mQ[mQ.size() - len + i]) v = v | (1 << i);
    end
    return v;
  endfunction

  always @(posedge clk) begin
    int len, frm, s1, s2, ones;
    bit setS, load, pf, ok, done1;
    len = 5 + int'(charLen);
    frm = len + int'(parityEn);
    s1 = int'(syncChar1) & ((1 << len) - 1);
    s2 = int'(syncChar2) & ((1 << len) - 1);
    setS = 0; load = 0; pf = 0; done1 = 0;
    if (!rstN) begin
      mSt = 0; mQ.delete();
      for (int i = 0; i < 8; i++) mQ.push_back(1'b1);
      mIdx = 0; mChar = 0; mPrev = 0; mHold = 0;
      mReady = 0; mOvr = 0; mPerr = 0; mSync = 0;
    end else begin
      if (enterHunt && !asyncMode) begin
        mSt = 0; mQ.delete();
        for (int i = 0; i < len; i++) mQ.push_back(1'b1);
        mIdx = 0; mChar = 0; mPrev = 0;
      end else if (!asyncMode) begin
        if (extSyncMode && syncIn && mSt != 3) begin
          setS = 1; mSt = 3; mIdx = 0; mChar = 0; mPrev = 0;
        end else begin
          if (extSyncMode && syncIn) setS = 1;
          if (bitStrobe) begin
            if (mSt == 0) begin
              if (!extSyncMode) begin
                mQ.push_back(rxData);
                if (mQ.size() > 8) void'(mQ.pop_front());
                if (windowVal(len) == s1) begin
                  if (parityEn) mSt = 1; else done1 = 1;
                end
              end
            end else if (mSt == 1) begin
              done1 = 1;
            end else begin
              if (mIdx < len) begin
                mQ.push_back(rxData);
                if (mQ.size() > 8) void'(mQ.pop_front());
                if (rxData) mChar = mChar | (1 << mIdx);
              end
              if (mIdx == frm - 1) begin
                if (mSt == 2) begin
                  if (mChar == s2) begin mSt = 3; setS = 1; mPrev = 0; end
                  else mSt = 0;
                end else begin
                  if (rxEnable) begin load = 1; end
                  if (parityEn) begin
                    ones = $countones(mChar) + int'(rxData);
                    ok = parityEven ? (ones % 2 == 0) : (ones % 2 == 1);
                    pf = !ok;
                  end
                  if (!extSyncMode) begin
                    if (singleSync) setS = setS | (mChar == s1);
                    else setS = setS | (mPrev && mChar == s2);
                    mPrev = (mChar == s1);
                  end
                  if (load) mHold = mChar;
                end
                mIdx = 0; mChar = 0;
              end else begin
                mIdx++;
              end
            end
            if (done1) begin
              mIdx = 0; mChar = 0;
              if (singleSync) begin mSt = 3; setS = 1; mPrev = 0; end
              else mSt = 2;
            end
          end
        end
      end
      if (setS) mSync = 1; else if (statusRead) mSync = 0;
      if (load && mReady) mOvr = 1; else if (errorReset) mOvr = 0;
      if (pf) mPerr = 1; else if (errorReset) mPerr = 0;
      if (!rxEnable) mReady = 0; else if (load) mReady = 1; else if (dataRead) mReady = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2", "model hunting", int'(hunting), int'(mSt != 3));
      check("R5", "model syncDetect", int'(syncDetect), int'(mSync));
      check("R8", "model rxReady", int'(rxReady), int'(mReady));
      check("R8", "model rxDataOut", int'(rxDataOut), mHold);
      check("R10", "model parityErr", int'(parityErr), int'(mPerr));
      check("R11", "model overrunErr", int'(overrunErr), int'(mOvr));
    end
  end

  task automatic sendBit(bit b);
    @(negedge clk); rxData = b; bitStrobe = 1'b1;
    @(negedge clk); bitStrobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendData(int v);
    for (int i = 0; i < 5 + int'(charLen); i++) sendBit(v[i]);
  endtask

  task automatic sendPar(int v, bit good);
    bit x = 0;
    for (int i = 0; i < 5 + int'(charLen); i++) x = x ^ v[i];
    if (!parityEven) x = !x;
    if (!good) x = !x;
    sendBit(x);
  endtask

  task automatic sendChar(int v, bit good);
    sendData(v);
    if (parityEn) sendPar(v, good);
  endtask

  task automatic doEnterHunt();
    @(negedge clk); enterHunt = 1'b1; @(negedge clk); enterHunt = 1'b0;
  endtask
  task automatic doStatusRead();
    @(negedge clk); statusRead = 1'b1; @(negedge clk); statusRead = 1'b0;
  endtask
  task automatic doDataRead();
    @(negedge clk); dataRead = 1'b1; @(negedge clk); dataRead = 1'b0;
  endtask
  task automatic doErrReset();
    @(negedge clk); errorReset = 1'b1; @(negedge clk); errorReset = 1'b0;
  endtask
  task automatic doSyncIn();
    @(negedge clk); syncIn = 1'b1; @(negedge clk); syncIn = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "hunting", int'(hunting), 1);
    check("R1", "syncDetect", int'(syncDetect), 0);
    check("R1", "rxReady", int'(rxReady), 0);
    check("R1", "rxDataOut", int'(rxDataOut), 0);
    check("R1", "errors", int'(parityErr) + int'(overrunErr), 0);

    // R2 single sync, 8 bits, no parity
    sendBit(0); sendBit(0);
    sendData(8'h16);
    check("R2", "hunting after sync", int'(hunting), 0);
    check("R2", "syncDetect after sync", int'(syncDetect), 1);
    doStatusRead();
    check("R5", "syncDetect cleared", int'(syncDetect), 0);
    check("R5", "still locked", int'(hunting), 0);

    // R8 assembly and read
    sendChar(8'hA5, 1);
    check("R8", "rxDataOut", int'(rxDataOut), 8'hA5);
    check("R8", "rxReady set", int'(rxReady), 1);
    doDataRead();
    check("R8", "rxReady cleared", int'(rxReady), 0);

    // R9 boundary sync, single
    sendChar(8'h16, 1);
    check("R9", "boundary syncDetect", int'(syncDetect), 1);

    // R11 overrun
    sendChar(8'h3C, 1);
    check("R11", "overrun", int'(overrunErr), 1);
    check("R11", "replaced data", int'(rxDataOut), 8'h3C);
    doErrReset();
    check("R11", "overrun cleared", int'(overrunErr), 0);

    // R12 receive disabled
    rxEnable = 1'b0;
    @(negedge clk);
    check("R12", "ready held low", int'(rxReady), 0);
    sendChar(8'h77, 1);
    check("R12", "no transfer", int'(rxDataOut), 8'h3C);
    check("R12", "ready still low", int'(rxReady), 0);
    rxEnable = 1'b1;

    // R7 async mode ignores everything
    asyncMode = 1'b1;
    doEnterHunt();
    check("R7", "enterHunt ignored", int'(hunting), 0);
    sendBit(1); sendBit(0); sendBit(1);
    check("R7", "bits ignored", int'(rxReady), 0);
    asyncMode = 1'b0;
    sendChar(8'h5E, 1);
    check("R7", "alignment kept", int'(rxDataOut), 8'h5E);
    doDataRead();

    // R6 preset ones on hunt entry
    doStatusRead();
    charLen = 2'd1; syncChar1 = 8'h3F;
    doEnterHunt();
    check("R6", "hunting after command", int'(hunting), 1);
    sendBit(1);
    check("R6", "all-ones sync found on first one", int'(hunting), 0);
    check("R6", "syncDetect", int'(syncDetect), 1);

    // R4 single sync with odd parity
    doStatusRead();
    charLen = 2'd2; parityEn = 1'b1; parityEven = 1'b0; syncChar1 = 8'h12;
    doEnterHunt();
    sendData(8'h12);
    check("R4", "no lock on last data bit", int'(hunting), 1);
    check("R4", "no flag on last data bit", int'(syncDetect), 0);
    sendPar(8'h12, 1);
    check("R4", "lock on parity bit", int'(hunting), 0);
    check("R4", "flag on parity bit", int'(syncDetect), 1);

    // R10 parity checks
    sendChar(8'h0B, 1);
    check("R10", "good parity", int'(parityErr), 0);
    check("R10", "7-bit data", int'(rxDataOut), 8'h0B);
    doDataRead();
    sendChar(8'h0B, 0);
    check("R10", "bad parity", int'(parityErr), 1);
    doErrReset();
    check("R10", "cleared", int'(parityErr), 0);
    doDataRead();
    rxEnable = 1'b0;
    sendChar(8'h21, 0);
    check("R10", "checked while disabled", int'(parityErr), 1);
    rxEnable = 1'b1;
    doErrReset();

    // R3 double sync
    doStatusRead();
    singleSync = 1'b0; syncChar2 = 8'h4D;
    doEnterHunt();
    sendChar(8'h12, 1);
    check("R3", "waiting for second", int'(hunting), 1);
    sendChar(8'h33, 1);
    check("R3", "wrong second keeps hunt", int'(hunting), 1);
    check("R3", "no flag", int'(syncDetect), 0);
    doEnterHunt();
    sendChar(8'h12, 1);
    sendData(8'h4D);
    check("R4", "double: no flag before parity", int'(syncDetect), 0);
    sendPar(8'h4D, 1);
    check("R3", "locked on pair", int'(hunting), 0);
    check("R3", "flag on pair", int'(syncDetect), 1);
    doStatusRead();
    sendChar(8'h12, 1);
    check("R9", "first of pair alone", int'(syncDetect), 0);
    sendChar(8'h4D, 1);
    check("R9", "pair at boundary", int'(syncDetect), 1);
    doDataRead(); doErrReset();

    // R13 external sync
    doStatusRead();
    extSyncMode = 1'b1; singleSync = 1'b1; parityEn = 1'b0;
    charLen = 2'd0; syncChar1 = 8'h13;
    doEnterHunt();
    sendData(8'h13);
    check("R13", "pattern ignored", int'(hunting), 1);
    doSyncIn();
    check("R13", "sync input locks", int'(hunting), 0);
    check("R13", "flag from input", int'(syncDetect), 1);
    doStatusRead();
    sendChar(8'h13, 1);
    check("R13", "first character", int'(rxDataOut), 8'h13);
    check("R13", "internal match off", int'(syncDetect), 0);
    doDataRead();
    sendChar(8'h0A, 1);
    check("R13", "second character", int'(rxDataOut), 8'h0A);

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule